// File: doc/BRIEF.md
# Resistor Discharge-Time Capture Sequencer

This block digitises resistive sensors without an analog-to-digital converter. Each column has a capacitor and a set of resistors tied to ordinary digital pins. The capacitor is charged and then left to discharge through one resistor at a time, while the block counts clock cycles until the capacitor node, read through a digital input, drops below the logic threshold. The count for the sensor resistor is later compared with the counts for known calibration resistors. That comparison cancels slow drift in capacitance, threshold and supply. The ratio arithmetic is not part of this block.

A conversion steps through a fixed order: the small calibration resistor, then the large calibration resistor if it is enabled, then the sensor. Each timed discharge follows its own charge phase. All columns share one pin-enable sequence and are timed in parallel, each with its own counter. In the two fast modes, the sensor's discharge is started through the small calibration resistor and handed over to the sensor after a set number of cycles. This shortens conversions of large resistances. Each fast mode has its own handover length. A saturating timeout limits every timed phase. A one-cycle done pulse marks the point at which all counts are final.

Top module: `rc_discharge_capture`

## Requirements
- R1: After reset, chg_o, dis_sel_o, done_o, every count and every overflow flag read zero.
- R2: Before each timed discharge, chg_o is high for exactly chg_cycles_i consecutive cycles (chg_cycles_i >= 3). While chg_o is high, dis_sel_o is zero.
- R3: dis_sel_o is zero or one-hot: bit 0 selects the small calibration resistor, bit 1 the large one and bit 2 the sensor. Within a conversion the paths run in the order bit 0, bit 1, bit 2, and the count for path p lands in cnt_o[c][p].
- R4: If a column's sense_i is first sampled low on the k-th rising edge after the edge that enabled the path, that column's count for the path is k+1. Each column is timed on its own.
- R5: If k+1 >= timeout_i, the path's count is all ones and its overflow flag is 1. Otherwise the flag is 0.
- R6: In mode_i=1 (or mode_i=2), the sensor's charge phase is followed by split_a_i (or split_b_i) cycles with dis_sel_o=001, then dis_sel_o=100 with no charge in between. The sensor count is referenced to the edge that enables bit 2. The handover length is sampled at start_i. Modes 0 and 3 discharge the sensor directly.
- R7: With two_cal_i=0 (sampled at start), the large calibration path is skipped, and its count and flag read 0 after the conversion.
- R8: done_o pulses for exactly one cycle after every column has finished the sensor path. The counts and flags then hold until the next start.
- R9: start_i is ignored while a conversion is in progress. After done, no further phase begins without a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a conversion (taken only when idle) |
| mode_i | input | 2 | 0/3 direct sensor discharge, 1 fast variant A, 2 fast variant B |
| two_cal_i | input | 1 | 1: time both calibration resistors, 0: only the small one |
| chg_cycles_i | input | CNT_W | Charge-phase length in cycles |
| split_a_i | input | CNT_W | Handover length for fast variant A |
| split_b_i | input | CNT_W | Handover length for fast variant B |
| timeout_i | input | CNT_W | Count limit per timed discharge |
| sense_i | input | N_COL | Capacitor node level per column (asynchronous) |
| chg_o | output | 1 | Drive all capacitor pins high |
| dis_sel_o | output | 3 | One-hot discharge path enable (cal small, cal large, sensor) |
| done_o | output | 1 | One-cycle conversion-complete strobe |
| cnt_o | output | N_COL*3*CNT_W | Count per column and path |
| ovf_o | output | N_COL*3 | Timeout flag per column and path |

## Verification
The hardest case to reach from the ports is a fast-mode sensor discharge whose columns end at different times: some are still counting, one times out, and the handover has just switched the pins. The bench stands in for the analog side. On every falling edge it watches chg_o and dis_sel_o, tells the handover segment apart from the small-resistor measurement by its position in the conversion, and lowers each column's sense input a chosen number of cycles after its path is enabled. A sweep over charge length, mode and calibration count, with per-column delays that straddle the timeout, covers every path and ending.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  localparam int unsigned N_PATH = 3;

  typedef enum logic [1:0] {
    P_CAL_LO = 2'd0,
    P_CAL_HI = 2'd1,
    P_SENS   = 2'd2
  } path_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHG,
    S_PRE,
    S_DIS,
    S_DONE
  } state_e;

  typedef enum logic [1:0] {
    M_FULL     = 2'd0,
    M_SPLIT_A  = 2'd1,
    M_SPLIT_B  = 2'd2,
    M_FULL_ALT = 2'd3
  } mode_e;
endpackage

// File: rtl/rdc_sync.sv
module rdc_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  // reset high: a charged node must not read as an early crossing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rdc_col_timer.sv
module rdc_col_timer
  import rdc_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_all_i,
  input  logic                           clr_i,
  input  logic                           run_i,
  input  logic [1:0]                     path_i,
  input  logic                           low_i,
  input  logic [CNT_W-1:0]               timeout_i,
  output logic [N_PATH-1:0][CNT_W-1:0]   cnt_o,
  output logic [N_PATH-1:0]              ovf_o,
  output logic                           fin_o
);
  logic [N_PATH-1:0][CNT_W-1:0] cnt_q;
  logic [N_PATH-1:0]            ovf_q;
  logic                         fin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= '0;
      fin_q <= 1'b0;
    end else if (clr_all_i) begin
      cnt_q <= '0;
      ovf_q <= '0;
      fin_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q[path_i] <= '0;
      ovf_q[path_i] <= 1'b0;
      fin_q         <= 1'b0;
    end else if (run_i && !fin_q) begin
      if (low_i) begin
        fin_q <= 1'b1;
      end else if (cnt_q[path_i] == timeout_i - 1'b1) begin
        cnt_q[path_i] <= '1;
        ovf_q[path_i] <= 1'b1;
        fin_q         <= 1'b1;
      end else begin
        cnt_q[path_i] <= cnt_q[path_i] + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
  assign fin_o = fin_q;

  for (genvar p = 0; p < N_PATH; p++) begin : g_chk
    AST_OVF_SATURATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_q[p] |-> cnt_q[p] == '1); // R5
  end

  AST_FIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_q && !clr_i && !clr_all_i) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/rdc_seq.sv
module rdc_seq
  import rdc_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic             two_cal_i,
  input  logic [CNT_W-1:0] chg_cycles_i,
  input  logic [CNT_W-1:0] split_a_i,
  input  logic [CNT_W-1:0] split_b_i,
  input  logic             all_fin_i,
  output logic             chg_o,
  output logic [2:0]       dis_sel_o,
  output logic [1:0]       path_o,
  output logic             clr_all_o,
  output logic             clr_o,
  output logic             run_o,
  output logic             done_o
);
  state_e           st_q, st_d;
  path_e            path_q, path_d;
  logic [CNT_W-1:0] tmr_q, tmr_d;
  logic [CNT_W-1:0] split_len_q;
  logic             split_q, two_q;
  mode_e            mode;

  assign mode = mode_e'(mode_i);

  always_comb begin
    st_d      = st_q;
    path_d    = path_q;
    tmr_d     = tmr_q;
    clr_all_o = 1'b0;
    clr_o     = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_d      = S_CHG;
        path_d    = P_CAL_LO;
        tmr_d     = '0;
        clr_all_o = 1'b1;
      end
      S_CHG: if (tmr_q == chg_cycles_i - 1'b1) begin
        tmr_d = '0;
        if (path_q == P_SENS && split_q) st_d = S_PRE;
        else begin
          st_d  = S_DIS;
          clr_o = 1'b1;
        end
      end else tmr_d = tmr_q + 1'b1;
      // sensor discharge begun through the small calibration resistor
      S_PRE: if (tmr_q == split_len_q - 1'b1) begin
        tmr_d = '0;
        st_d  = S_DIS;
        clr_o = 1'b1;
      end else tmr_d = tmr_q + 1'b1;
      S_DIS: if (all_fin_i) begin
        if (path_q == P_SENS) st_d = S_DONE;
        else begin
          st_d   = S_CHG;
          path_d = (path_q == P_CAL_LO && two_q) ? P_CAL_HI : P_SENS;
        end
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      path_q      <= P_CAL_LO;
      tmr_q       <= '0;
      split_len_q <= '0;
      split_q     <= 1'b0;
      two_q       <= 1'b0;
    end else begin
      st_q   <= st_d;
      path_q <= path_d;
      tmr_q  <= tmr_d;
      if (st_q == S_IDLE && start_i) begin
        split_q     <= (mode == M_SPLIT_A) || (mode == M_SPLIT_B);
        split_len_q <= (mode == M_SPLIT_A) ? split_a_i : split_b_i;
        two_q       <= two_cal_i;
      end
    end
  end

  always_comb begin
    dis_sel_o = '0;
    if (st_q == S_PRE)      dis_sel_o = 3'b001;
    else if (st_q == S_DIS) dis_sel_o = 3'b001 << path_q;
  end

  assign chg_o  = (st_q == S_CHG);
  assign run_o  = (st_q == S_DIS);
  assign done_o = (st_q == S_DONE);
  assign path_o = path_q;

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dis_sel_o)); // R3
  AST_CHG_NO_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> dis_sel_o == 3'b000); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_AFTER_FIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(all_fin_i && dis_sel_o == 3'b100)); // R8
endmodule

// File: rtl/rc_discharge_capture.sv
module rc_discharge_capture
  import rdc_pkg::*;
#(
  parameter int unsigned N_COL = 4,
  parameter int unsigned CNT_W = 12
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     start_i,
  input  logic [1:0]                               mode_i,
  input  logic                                     two_cal_i,
  input  logic [CNT_W-1:0]                         chg_cycles_i,
  input  logic [CNT_W-1:0]                         split_a_i,
  input  logic [CNT_W-1:0]                         split_b_i,
  input  logic [CNT_W-1:0]                         timeout_i,
  input  logic [N_COL-1:0]                         sense_i,
  output logic                                     chg_o,
  output logic [2:0]                               dis_sel_o,
  output logic                                     done_o,
  output logic [N_COL-1:0][N_PATH-1:0][CNT_W-1:0]  cnt_o,
  output logic [N_COL-1:0][N_PATH-1:0]             ovf_o
);
  logic [N_COL-1:0] sense_s, fin;
  logic [1:0]       path;
  logic             clr_all, clr, run;

  rdc_sync #(.WIDTH(N_COL)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sense_i),
    .q_o   (sense_s)
  );

  rdc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .two_cal_i   (two_cal_i),
    .chg_cycles_i(chg_cycles_i),
    .split_a_i   (split_a_i),
    .split_b_i   (split_b_i),
    .all_fin_i   (&fin),
    .chg_o       (chg_o),
    .dis_sel_o   (dis_sel_o),
    .path_o      (path),
    .clr_all_o   (clr_all),
    .clr_o       (clr),
    .run_o       (run),
    .done_o      (done_o)
  );

  for (genvar c = 0; c < N_COL; c++) begin : g_col
    rdc_col_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_all_i(clr_all),
      .clr_i    (clr),
      .run_i    (run),
      .path_i   (path),
      .low_i    (~sense_s[c]),
      .timeout_i(timeout_i),
      .cnt_o    (cnt_o[c]),
      .ovf_o    (ovf_o[c]),
      .fin_o    (fin[c])
    );
  end
endmodule

// File: tb/rc_discharge_capture_tb.sv
module rc_discharge_capture_tb;
  localparam int NC = 3;
  localparam int W  = 12;
  localparam int TO = 40;
  localparam int SPA = 5;
  localparam int SPB = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         start = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic         two_cal = 1'b1;
  logic [W-1:0] chg_cyc = W'(4);
  logic [W-1:0] split_a = W'(SPA);
  logic [W-1:0] split_b = W'(SPB);
  logic [W-1:0] timeout = W'(TO);
  logic [NC-1:0] sense = '1;
  logic          chg, done;
  logic [2:0]    sel;
  logic [NC-1:0][2:0][W-1:0] cnt, cnt_snap;
  logic [NC-1:0][2:0]        ovf, ovf_snap;

  int errors = 0, checks = 0, cycles = 0;
  int dly[NC][3];
  bit mon_on = 0, split_on = 0;
  int kind, prev_kind = 0, run_len = 0, seg001 = 0, t = 0;
  int log_k[16], log_l[16], nlog = 0;
  int exp_k[16], exp_l[16], nexp = 0;

  rc_discharge_capture #(.N_COL(NC), .CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .two_cal_i(two_cal), .chg_cycles_i(chg_cyc), .split_a_i(split_a),
    .split_b_i(split_b), .timeout_i(timeout), .sense_i(sense),
    .chg_o(chg), .dis_sel_o(sel), .done_o(done), .cnt_o(cnt), .ovf_o(ovf)
  );

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // analog stand-in and phase logger
  always @(negedge clk) begin
    kind = chg ? 8 : int'(sel);
    if (kind != prev_kind) begin
      if (mon_on && prev_kind != 0 && nlog < 16) begin
        log_k[nlog] = prev_kind;
        log_l[nlog] = run_len;
        nlog++;
      end
      run_len = 1;
      t = 0;
      if (kind == 1) seg001++;
    end else run_len++;
    prev_kind = kind;
    if ((kind == 1 || kind == 2 || kind == 4) && !(kind == 1 && split_on && seg001 == 2)) begin
      int p;
      t++;
      p = (kind == 1) ? 0 : (kind == 2) ? 1 : 2;
      for (int c = 0; c < NC; c++) sense[c] = (t <= dly[c][p]);
    end else sense = '1;
  end

  function automatic int fin_edge(int d);
    return (d + 2 < TO) ? d + 3 : TO;
  endfunction

  function automatic int dis_len(int p);
    int m = 0;
    for (int c = 0; c < NC; c++) if (fin_edge(dly[c][p]) > m) m = fin_edge(dly[c][p]);
    return m + 1;
  endfunction

  task automatic push_exp(int k, int l);
    exp_k[nexp] = k;
    exp_l[nexp] = l;
    nexp++;
  endtask

  task automatic run_conv(int m, int two, int chgc, int seed);
    bit got_done = 0;
    bit split = (m == 1 || m == 2);
    for (int c = 0; c < NC; c++)
      for (int p = 0; p < 3; p++) dly[c][p] = (c * 13 + p * 7 + seed * 5) % 44;
    mode = 2'(m);
    two_cal = 1'(two);
    chg_cyc = W'(chgc);
    nlog = 0; seg001 = 0; split_on = split; mon_on = 1;
    nexp = 0;
    push_exp(8, chgc); push_exp(1, dis_len(0));
    if (two != 0) begin push_exp(8, chgc); push_exp(2, dis_len(1)); end
    push_exp(8, chgc);
    if (split) push_exp(1, (m == 1) ? SPA : SPB);
    push_exp(4, dis_len(2));
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      start = (i == 8);  // R9: start while busy
      @(posedge clk); #1;
      if (done) begin got_done = 1; break; end
    end
    start = 1'b0;
    chk("R8 done seen", int'(got_done), 1);
    cnt_snap = cnt;
    ovf_snap = ovf;
    for (int c = 0; c < NC; c++)
      for (int p = 0; p < 3; p++) begin
        int ec, eo;
        if (p == 1 && two == 0) begin ec = 0; eo = 0; end
        else if (dly[c][p] + 2 < TO) begin ec = dly[c][p] + 2; eo = 0; end
        else begin ec = (1 << W) - 1; eo = 1; end
        if (p == 1 && two == 0) begin
          chk("R7 skipped cal count", int'(cnt[c][p]), ec);
          chk("R7 skipped cal flag", int'(ovf[c][p]), eo);
        end else if (p == 2 && split) begin
          chk("R6 sensor count after handover", int'(cnt[c][p]), ec);
          chk("R5 sensor flag", int'(ovf[c][p]), eo);
        end else begin
          chk("R4 count", int'(cnt[c][p]), ec);
          chk("R5 overflow flag", int'(ovf[c][p]), eo);
        end
      end
    @(posedge clk); #1;
    chk("R8 done one cycle", int'(done), 0);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk("R9 idle after done chg", int'(chg), 0);
      chk("R9 idle after done sel", int'(sel), 0);
    end
    chk("R8 counts held", int'(cnt == cnt_snap), 1);
    chk("R8 flags held", int'(ovf == ovf_snap), 1);
    mon_on = 0;
    chk("R3 phase count", nlog, nexp);
    for (int i = 0; i < nexp && i < nlog; i++) begin
      if (exp_k[i] == 8) chk("R2 charge phase", log_k[i], 8);
      else chk("R3 path order", log_k[i], exp_k[i]);
      if (split && exp_k[i] == 1 && i == nexp - 2)
        chk("R6 handover length", log_l[i], exp_l[i]);
      else if (exp_k[i] == 8) chk("R2 charge length", log_l[i], exp_l[i]);
      else chk("R4 discharge length", log_l[i], exp_l[i]);
    end
  endtask

  initial begin
    int seed = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset chg", int'(chg), 0);
    chk("R1 reset sel", int'(sel), 0);
    chk("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset counts", int'(cnt == '0), 1);
    chk("R1 reset flags", int'(ovf == '0), 1);
    for (int cc = 0; cc < 2; cc++)
      for (int two = 0; two < 2; two++)
        for (int m = 0; m < 4; m++) begin
          run_conv(m, two, (cc == 0) ? 3 : 6, seed);
          seed++;
        end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule